// File: doc/BRIEF.md
# Multi-Width Aliased Floating-Point Word Store

This block holds floating-point register contents as one flat array of 32-bit words. Software-visible single, double and quad registers are views onto that array: an access names a starting word and a width, and covers one, two or four consecutive words from that start. The views share storage, so a wide write replaces several narrow registers, and a narrow read can pick out part of an earlier wide value.

There is one write port and one read port, and both work in the same cycle. Writes land at the clock edge. Reads are registered and return data one cycle after the request. Each port checks its own access. An access with an unsupported width code, or a span that would run past the last word, raises that port's error flag and leaves storage unchanged.

A synchronous clear zeroes the whole array. A build-time option reverses the byte order of each value across its access width on the way in and on the way out, so that values can move between a big-endian store and a little-endian datapath.

Top module: `fp_word_store`

## Requirements
- R1: Storage holds NUM_WORDS (default 64) words of 32 bits, and a 6-bit index selects a word. A single-width write followed by a single-width read at the same index returns the written word.
- R2: Width code 0 covers 1 word, code 1 covers 2 words and code 2 covers 4 words, starting at the index. In a multi-word access the lowest-indexed word carries the most-significant 32 bits. Data sits right-aligned on the 128-bit buses. Write-data bits above the access width are ignored, and read-data bits above it return zero.
- R3: Width code 3 is illegal. The port's error flag rises one cycle after the request, storage is not changed, and a read returns all-zero data.
- R4: An access with index + word count greater than NUM_WORDS raises the port's error flag one cycle later and has no effect on storage. A read of this kind returns zero.
- R5: A legal write changes only the words inside its span. All other words keep their values.
- R6: Read data is due one cycle after the request. A read issued in the cycle after a write sees the new data. A read issued in the same cycle as a write to the same words returns the old data.
- R7: Reset and clear both zero every word. A clear takes priority over a write issued in the same cycle.
- R8: With SWAP_BYTES=1, the bytes of each value are reversed across the access width on write and again on read. For example, a double 0x0011223344556677 written at index i reads back unchanged as a double, but reads as the single 0x44556677 at index i.
- R9: rd_valid is high exactly one cycle after each rd_en. wr_err is high exactly one cycle after an illegal enabled write and low at all other times. Both are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all words |
| wr_en | input | 1 | Write request |
| wr_idx | input | 6 | Starting word index of the write |
| wr_wid | input | 2 | Write width code (0 single, 1 double, 2 quad, 3 illegal) |
| wr_data | input | 128 | Write value, right-aligned |
| rd_en | input | 1 | Read request |
| rd_idx | input | 6 | Starting word index of the read |
| rd_wid | input | 2 | Read width code |
| rd_valid | output | 1 | Read result present (one cycle after rd_en) |
| rd_err | output | 1 | Read request was illegal |
| rd_data | output | 128 | Read value, right-aligned, zero-filled above the width |
| wr_err | output | 1 | Write request was illegal |

## Verification
Every result is due exactly one edge after its request: the read data, rd_valid, rd_err and wr_err all come from registers loaded at that edge. A write's effect on storage also shows up one cycle later, through a read. The bench drives each request at a falling edge and predicts the outcome from its word model before it applies the same write to that model. It then compares at the next falling edge, which puts the check half a cycle after the edge that produced the value. This ordering also gives the correct prediction for a read issued in the same cycle as a write: the read returns the old data.

// File: rtl/fpws_pkg.sv
package fpws_pkg;

    typedef enum logic [1:0] {
        FW_SINGLE = 2'd0,
        FW_DOUBLE = 2'd1,
        FW_QUAD   = 2'd2,
        FW_BAD    = 2'd3
    } fw_width_e;

    // number of 32-bit words an access width spans (0 when illegal)
    function automatic int unsigned words_of(input logic [1:0] wid);
        case (fw_width_e'(wid))
            FW_SINGLE: return 1;
            FW_DOUBLE: return 2;
            FW_QUAD:   return 4;
            default:   return 0;
        endcase
    endfunction

endpackage

// File: rtl/fpws_span_check.sv
module fpws_span_check #(
    parameter int NUM_WORDS = 64,
    parameter int IDX_W     = $clog2(NUM_WORDS),
    parameter int CNT_W     = 3
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [1:0]       wid,
    output logic             legal,
    output logic [CNT_W-1:0] cnt
);
    import fpws_pkg::*;

    int unsigned n_words;

    always_comb begin
        n_words = words_of(wid);
        cnt     = CNT_W'(n_words);
        legal   = (n_words != 0) && ((int'(idx) + int'(n_words)) <= NUM_WORDS);
    end

endmodule

// File: rtl/fpws_byte_swap.sv
module fpws_byte_swap #(
    parameter bit ENABLE = 1'b0,
    parameter int WORD_W = 32,
    parameter int DATA_W = 128
) (
    input  logic [DATA_W-1:0] din,
    input  logic [1:0]        wid,
    output logic [DATA_W-1:0] dout
);
    import fpws_pkg::*;

    localparam int BYTES_PER_WORD = WORD_W / 8;
    localparam int NUM_BYTES      = DATA_W / 8;

    int n_bytes;

    always_comb begin
        n_bytes = int'(words_of(wid)) * BYTES_PER_WORD;
        dout    = din;
        if (ENABLE && n_bytes != 0) begin
            for (int b = 0; b < NUM_BYTES; b++) begin
                if (b < n_bytes) begin
                    dout[8*b +: 8] = din[8*(n_bytes-1-b) +: 8];
                end
            end
        end
    end

endmodule

// File: rtl/fp_word_store.sv
module fp_word_store #(
    parameter int NUM_WORDS  = 64,
    parameter int WORD_W     = 32,
    parameter int MAX_WORDS  = 4,
    parameter bit SWAP_BYTES = 1'b0,
    localparam int IDX_W     = $clog2(NUM_WORDS),
    localparam int DATA_W    = WORD_W * MAX_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [1:0]        wr_wid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [1:0]        rd_wid,
    output logic              rd_valid,
    output logic              rd_err,
    output logic [DATA_W-1:0] rd_data,
    output logic              wr_err
);
    localparam int CNT_W = $clog2(MAX_WORDS + 1);

    typedef struct packed {
        logic [NUM_WORDS-1:0][WORD_W-1:0] mem;
        logic [DATA_W-1:0]                rd_data;
        logic                             rd_valid;
        logic                             rd_err;
        logic                             wr_err;
    } state_t;

    state_t st_d, st_q;

    logic             wr_ok, rd_ok;
    logic [CNT_W-1:0] wr_cnt, rd_cnt;
    logic [DATA_W-1:0] wr_fmt, rd_raw, rd_fmt;

    fpws_span_check #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_wr_span (
        .idx(wr_idx), .wid(wr_wid), .legal(wr_ok), .cnt(wr_cnt)
    );

    fpws_span_check #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_rd_span (
        .idx(rd_idx), .wid(rd_wid), .legal(rd_ok), .cnt(rd_cnt)
    );

    fpws_byte_swap #(.ENABLE(SWAP_BYTES), .WORD_W(WORD_W), .DATA_W(DATA_W)) u_wr_swap (
        .din(wr_data), .wid(wr_wid), .dout(wr_fmt)
    );

    fpws_byte_swap #(.ENABLE(SWAP_BYTES), .WORD_W(WORD_W), .DATA_W(DATA_W)) u_rd_swap (
        .din(rd_raw), .wid(rd_wid), .dout(rd_fmt)
    );

    // gather the read span: lowest index lands in the most-significant slot
    always_comb begin
        rd_raw = '0;
        if (rd_ok) begin
            for (int k = 0; k < MAX_WORDS; k++) begin
                if (k < int'(rd_cnt)) begin
                    rd_raw[(int'(rd_cnt)-1-k)*WORD_W +: WORD_W] = st_q.mem[rd_idx + IDX_W'(k)];
                end
            end
        end
    end

    always_comb begin
        st_d          = st_q;
        st_d.rd_valid = rd_en;
        st_d.rd_err   = rd_en && !rd_ok;
        st_d.rd_data  = (rd_en && rd_ok) ? rd_fmt : '0;
        st_d.wr_err   = wr_en && !wr_ok;
        if (clr) begin
            st_d.mem = '0;
        end else if (wr_en && wr_ok) begin
            for (int k = 0; k < MAX_WORDS; k++) begin
                if (k < int'(wr_cnt)) begin
                    st_d.mem[wr_idx + IDX_W'(k)] = wr_fmt[(int'(wr_cnt)-1-k)*WORD_W +: WORD_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_valid = st_q.rd_valid;
    assign rd_err   = st_q.rd_err;
    assign rd_data  = st_q.rd_data;
    assign wr_err   = st_q.wr_err;

endmodule

// File: rtl/fpws_checker.sv
module fpws_checker #(
    parameter int NUM_WORDS = 64,
    parameter int IDX_W     = 6,
    parameter int DATA_W    = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [1:0]        wr_wid,
    input logic              rd_en,
    input logic [IDX_W-1:0]  rd_idx,
    input logic [1:0]        rd_wid,
    input logic              rd_valid,
    input logic              rd_err,
    input logic [DATA_W-1:0] rd_data,
    input logic              wr_err
);
    // R3
    bad_width_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_wid == 2'd3) |=> (rd_err && rd_data == '0));

    // R3
    bad_width_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_wid == 2'd3) |=> wr_err);

    // R4
    span_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_wid == 2'd1 && rd_idx == IDX_W'(NUM_WORDS-1)) |=> rd_err);

    // R9
    rd_valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rd_valid == $past(rd_en)));

    // R9
    wr_err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !wr_err);

    // R7
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr ##1 rd_en |=> (rd_data == '0));

endmodule

bind fp_word_store fpws_checker #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_wid(wr_wid),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_wid(rd_wid),
    .rd_valid(rd_valid), .rd_err(rd_err), .rd_data(rd_data), .wr_err(wr_err)
);

// File: tb/fp_word_store_bench.sv
`timescale 1ns/1ps
module fp_word_store_bench;
    localparam int NW = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clr = 1'b0;
    logic         wr_en = 1'b0;
    logic [5:0]   wr_idx = '0;
    logic [1:0]   wr_wid = '0;
    logic [127:0] wr_data = '0;
    logic         rd_en = 1'b0;
    logic [5:0]   rd_idx = '0;
    logic [1:0]   rd_wid = '0;
    logic         rd_valid, rd_err, wr_err;
    logic [127:0] rd_data;
    logic         s_rd_valid, s_rd_err, s_wr_err;
    logic [127:0] s_rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [31:0] model [NW];

    always #4 clk = ~clk;

    fp_word_store u_fp_word_store (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_wid(wr_wid), .wr_data(wr_data),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_wid(rd_wid),
        .rd_valid(rd_valid), .rd_err(rd_err), .rd_data(rd_data), .wr_err(wr_err)
    );

    fp_word_store #(.SWAP_BYTES(1'b1)) u_fp_word_store_swap (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_wid(wr_wid), .wr_data(wr_data),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_wid(rd_wid),
        .rd_valid(s_rd_valid), .rd_err(s_rd_err), .rd_data(s_rd_data), .wr_err(s_wr_err)
    );

    function automatic int span(input logic [1:0] w);
        return (w == 2'd0) ? 1 : (w == 2'd1) ? 2 : (w == 2'd2) ? 4 : 0;
    endfunction

    function automatic bit legal(input logic [5:0] i, input logic [1:0] w);
        return span(w) != 0 && (int'(i) + span(w)) <= NW;
    endfunction

    function automatic logic [127:0] model_read(input logic [5:0] i, input logic [1:0] w);
        logic [127:0] r = '0;
        int n = span(w);
        if (legal(i, w))
            for (int k = 0; k < n; k++) r[(n-1-k)*32 +: 32] = model[int'(i)+k];
        return r;
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // drive one cycle at a falling edge, predict, and compare at the next falling edge
    task automatic step(input bit c, input bit we, input logic [5:0] wi, input logic [1:0] ww,
                        input logic [127:0] wd, input bit re, input logic [5:0] ri,
                        input logic [1:0] rw);
        logic [127:0] exp_rd;
        bit exp_rerr, exp_werr;
        string rtag;
        clr = c; wr_en = we; wr_idx = wi; wr_wid = ww; wr_data = wd;
        rd_en = re; rd_idx = ri; rd_wid = rw;
        exp_rd    = re ? model_read(ri, rw) : 128'd0;
        exp_rerr  = re && !legal(ri, rw);
        exp_werr  = we && !legal(wi, ww);
        rtag      = !legal(ri, rw) ? ((rw == 2'd3) ? "R3" : "R4") : "R2";
        if (c) begin
            for (int k = 0; k < NW; k++) model[k] = '0;
        end else if (we && legal(wi, ww)) begin
            for (int k = 0; k < span(ww); k++) model[int'(wi)+k] = wd[(span(ww)-1-k)*32 +: 32];
        end
        @(negedge clk);
        chk("R9 rd_valid", {127'd0, rd_valid}, {127'd0, re});
        chk("R9 wr_err", {127'd0, wr_err}, {127'd0, exp_werr});
        if (re) begin
            chk({rtag, " rd_err"}, {127'd0, rd_err}, {127'd0, exp_rerr});
            chk({rtag, " rd_data"}, rd_data, exp_rd);
        end
    endtask

    task automatic idle();
        step(1'b0, 1'b0, 6'd0, 2'd0, 128'd0, 1'b0, 6'd0, 2'd0);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < NW; k++) model[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state of the flags
        chk("R9 reset rd_valid", {127'd0, rd_valid}, 128'd0);
        chk("R9 reset wr_err", {127'd0, wr_err}, 128'd0);
        // R7 storage zero after reset
        step(1'b0, 1'b0, 6'd0, 2'd0, 128'd0, 1'b1, 6'd0, 2'd2);

        // R1 single round trip
        step(1'b0, 1'b1, 6'd7, 2'd0, 128'hFFFF_0000_DEAD_BEEF, 1'b0, 6'd0, 2'd0);
        step(1'b0, 1'b0, 6'd0, 2'd0, 128'd0, 1'b1, 6'd7, 2'd0);
        chk("R1 single readback", rd_data, 128'hDEAD_BEEF);

        // R5 narrow write inside a quad leaves neighbours alone
        step(1'b0, 1'b1, 6'd20, 2'd2, {4{32'hAAAA_5555}}, 1'b0, 6'd0, 2'd0);
        step(1'b0, 1'b1, 6'd21, 2'd0, 128'h1234_5678, 1'b0, 6'd0, 2'd0);
        step(1'b0, 1'b0, 6'd0, 2'd0, 128'd0, 1'b1, 6'd20, 2'd2);
        chk("R5 quad after narrow write", rd_data,
            {32'hAAAA_5555, 32'h1234_5678, 32'hAAAA_5555, 32'hAAAA_5555});

        // R6 same-cycle read sees old data, next cycle sees new
        step(1'b0, 1'b1, 6'd5, 2'd0, 128'h0BAD_F00D, 1'b1, 6'd5, 2'd0);
        chk("R6 same-cycle old data", rd_data, 128'd0);
        step(1'b0, 1'b0, 6'd0, 2'd0, 128'd0, 1'b1, 6'd5, 2'd0);
        chk("R6 next-cycle new data", rd_data, 128'h0BAD_F00D);

        // R3 illegal width write leaves storage alone
        step(1'b0, 1'b1, 6'd20, 2'd3, {4{32'hFFFF_FFFF}}, 1'b0, 6'd0, 2'd0);
        step(1'b0, 1'b0, 6'd0, 2'd0, 128'd0, 1'b1, 6'd20, 2'd0);
        chk("R3 storage unchanged", rd_data, 128'hAAAA_5555);

        // R4 overrunning quad write has no effect
        step(1'b0, 1'b1, 6'd62, 2'd1, 128'h1111_1111_2222_2222, 1'b0, 6'd0, 2'd0);
        step(1'b0, 1'b1, 6'd62, 2'd2, {4{32'h7777_7777}}, 1'b0, 6'd0, 2'd0);
        chk("R4 overrun wr_err", {127'd0, wr_err}, 128'd1);
        step(1'b0, 1'b0, 6'd0, 2'd0, 128'd0, 1'b1, 6'd62, 2'd1);
        chk("R4 storage unchanged", rd_data, 128'h1111_1111_2222_2222);

        // R8 byte order reversal across the access width
        step(1'b0, 1'b1, 6'd10, 2'd1, 128'h0011_2233_4455_6677, 1'b0, 6'd0, 2'd0);
        step(1'b0, 1'b0, 6'd0, 2'd0, 128'd0, 1'b1, 6'd10, 2'd0);
        chk("R8 plain single view", rd_data, 128'h0011_2233);
        chk("R8 swapped single view", s_rd_data, 128'h4455_6677);
        step(1'b0, 1'b0, 6'd0, 2'd0, 128'd0, 1'b1, 6'd10, 2'd1);
        chk("R8 swapped double round trip", s_rd_data, 128'h0011_2233_4455_6677);

        // R7 clear wins over a write in the same cycle
        step(1'b1, 1'b1, 6'd30, 2'd0, 128'h5A5A_5A5A, 1'b0, 6'd0, 2'd0);
        step(1'b0, 1'b0, 6'd0, 2'd0, 128'd0, 1'b1, 6'd30, 2'd0);
        chk("R7 clear beats write", rd_data, 128'd0);
        step(1'b0, 1'b0, 6'd0, 2'd0, 128'd0, 1'b1, 6'd20, 2'd2);
        chk("R7 clear zeroes quad", rd_data, 128'd0);

        // random mix, checked by step against the model (R2, R3, R4, R9)
        for (int n = 0; n < 4000; n++) begin
            step(($urandom % 97) == 0,
                 ($urandom % 2) == 0, 6'($urandom), 2'($urandom),
                 {$urandom, $urandom, $urandom, $urandom},
                 ($urandom % 4) != 0, 6'($urandom), 2'($urandom));
        end
        idle();

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule